// File: doc/BRIEF.md
# Mirrored Coefficient Bank Loader

This block fills a 16-phase polyphase coefficient memory from a compact source table that holds only nine phases of seven 12-bit taps each. After a start pulse it walks through all sixteen output phases. For every phase it emits three packed 32-bit words onto a simple address/data/valid/ready write bus. Phases 0 to 8 come straight from the table. The upper seven phases are built by symmetry: each one reads a lower stored phase and reverses its taps. A mode bit chooses a seven-tap layout or a five-tap layout. In the five-tap layout the middle five taps are moved into the leading slots.

The table is read through a combinational port. The block drives a phase index and the table answers in the same cycle with all seven taps. The base address and the mode bit are captured when the start pulse is accepted. The block finishes with a one-cycle done pulse.

Top module: `mirrored_coef_loader`

## Requirements
- R1: After reset, wr_valid, busy and done are all low.
- R2: A start pulse while idle yields exactly 48 write handshakes. The order is output phase 0 to 15, and within each phase the word order is head (0), middle (1), tail (2). Only one write is transferred per cycle in which wr_valid and wr_ready are both high.
- R3: The write address for output phase p and word w is base + 0x40·w + 4·p. The base is the value of base_addr captured at the accepted start.
- R4: Output phases 0 to 8 take their taps from table phase p, with tap k placed in slot k.
- R5: Output phases 9 to 15 take their taps from table phase 16−p, with the tap order reversed: slot k receives tap 6−k.
- R6: In seven-tap mode (five_tap=0 at start), with slots s0..s6:
  - the head word is s0 in bits 27:16, s1 in bits 15:4, and s2[11:8] in bits 3:0;
  - the middle word is s2[7:0] in bits 27:20, s3 in bits 19:8, and s4[11:4] in bits 7:0;
  - the tail word is s4[3:0] in bits 27:24, s5 in bits 23:12, and s6 in bits 11:0.
- R7: In five-tap mode (five_tap=1 at start), slots s0..s4 hold the taps that sit in slots 1 to 5 after the R4/R5 ordering, and the same bit layout as R6 is used. The tail word then carries only s4[3:0] in bits 27:24, and all its other bits are zero. Bits 31:28 are zero in every word and in both modes.
- R8: While wr_valid is high and wr_ready is low, wr_valid stays high and wr_addr and wr_data stay unchanged on the next cycle.
- R9: done is high for exactly one cycle. That cycle is the one right after the 48th handshake. In that cycle wr_valid and busy are low.
- R10: A start pulse while busy is ignored. This holds even when it coincides with the final handshake. The run still makes exactly 48 writes, and no new run follows.
- R11: tbl_phase shows the table phase being read (p for p ≤ 8, 16−p otherwise) while wr_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted only while idle) |
| five_tap | input | 1 | 1 selects five-tap packing, 0 selects seven-tap packing |
| base_addr | input | ADDR_W | Base byte address of the coefficient bank |
| tbl_phase | output | 4 | Source table phase being read |
| tbl_row | input | 84 | Seven 12-bit taps of tbl_phase, tap k at bits 12k+11:12k |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Packed coefficient word |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Bus accepts the write when high with wr_valid |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
Two functions can land in the same cycle: the final write handshake, and the acceptance of a new start pulse. The bench raises start exactly in the cycle where the last word (phase 15, tail, address base+0xBC) is handed over. It also raises start in the middle of a run. It then judges the outcome at the ports: the write count must stay at 48, there must be a single done pulse, and wr_valid must stay low for several cycles afterwards. Stalls on wr_ready are mixed into separate runs. These check that the final handshake is the one that ends the run, not the cycle in which the last word is first offered.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    localparam int TAP_W    = 12;
    localparam int NTAP     = 7;
    localparam int NPHASE   = 16;
    localparam int NSTORED  = NPHASE / 2 + 1;
    localparam int WORD_W   = 32;
    localparam int PH_W     = $clog2(NPHASE);
    localparam int ROW_W    = NTAP * TAP_W;
    localparam int PH_STEP  = 4;
    localparam int BANK_STEP = NPHASE * PH_STEP;

    typedef logic [TAP_W-1:0] tap_t;
    typedef tap_t [NTAP-1:0]  row_t;

    typedef enum logic [1:0] {
        SLOT_HEAD = 2'd0,
        SLOT_MID  = 2'd1,
        SLOT_TAIL = 2'd2
    } slot_e;

    typedef struct packed {
        logic [PH_W-1:0] phase;
        slot_e           slot;
    } pos_t;

    function automatic logic [PH_W-1:0] src_phase(input logic [PH_W-1:0] ph);
        logic [PH_W:0] wide;
        wide = (PH_W+1)'(NPHASE) - {1'b0, ph};
        return (ph < PH_W'(NSTORED)) ? ph : wide[PH_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input row_t s, input slot_e w);
        logic [WORD_W-1:0] r;
        case (w)
            SLOT_HEAD: r = {4'h0, s[0], s[1], s[2][11:8]};
            SLOT_MID:  r = {4'h0, s[2][7:0], s[3], s[4][11:4]};
            default:   r = {4'h0, s[4][3:0], s[5], s[6]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbl_seq.sv
module cbl_seq
    import cbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic wr_ready,
    output logic busy,
    output logic accept,
    output pos_t pos,
    output logic done
);

    logic fire;
    logic last;

    assign accept = start && !busy;
    assign fire   = busy && wr_ready;
    assign last   = (pos.phase == PH_W'(NPHASE - 1)) && (pos.slot == SLOT_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            pos  <= '{phase: '0, slot: SLOT_HEAD};
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                pos  <= '{phase: '0, slot: SLOT_HEAD};
            end else if (fire) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (pos.slot == SLOT_TAIL) begin
                    pos.slot  <= SLOT_HEAD;
                    pos.phase <= pos.phase + 1'b1;
                end else begin
                    pos.slot <= slot_e'(pos.slot + 2'd1);
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(fire) && $past(last) && !busy)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(fire && last)) |=> (busy && $stable(pos) || $past(fire))); // R10

endmodule

// File: rtl/cbl_pack.sv
module cbl_pack
    import cbl_pkg::*;
(
    input  pos_t                pos,
    input  logic                five_tap,
    input  logic [ROW_W-1:0]    tbl_row,
    output logic [PH_W-1:0]     tbl_phase,
    output logic [WORD_W-1:0]   data
);

    row_t raw;
    row_t ordered;
    row_t slots;
    logic mirror;

    assign tbl_phase = src_phase(pos.phase);
    assign mirror    = (pos.phase >= PH_W'(NSTORED));

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign raw[k]     = tbl_row[k*TAP_W +: TAP_W];
        assign ordered[k] = mirror ? raw[NTAP-1-k] : raw[k];
        if (k < NTAP - 2) begin : g_lead
            assign slots[k] = five_tap ? ordered[k+1] : ordered[k];
        end else begin : g_trail
            assign slots[k] = five_tap ? '0 : ordered[k];
        end
    end

    assign data = pack_word(slots, pos.slot);

endmodule

// File: rtl/mirrored_coef_loader.sv
module mirrored_coef_loader
    import cbl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  five_tap,
    input  logic [ADDR_W-1:0]     base_addr,
    output logic [3:0]            tbl_phase,
    input  logic [83:0]           tbl_row,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [31:0]           wr_data,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic                  busy,
    output logic                  done
);

    localparam int SLOT_SH = $clog2(BANK_STEP);
    localparam int PH_SH   = $clog2(PH_STEP);

    pos_t              pos;
    logic              accept;
    logic              five_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ph_off;
    logic [ADDR_W-1:0] slot_off;

    cbl_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wr_ready (wr_ready),
        .busy     (busy),
        .accept   (accept),
        .pos      (pos),
        .done     (done)
    );

    cbl_pack u_pack (
        .pos       (pos),
        .five_tap  (five_q),
        .tbl_row   (tbl_row),
        .tbl_phase (tbl_phase),
        .data      (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            five_q <= 1'b0;
            base_q <= '0;
        end else if (accept) begin
            five_q <= five_tap;
            base_q <= base_addr;
        end
    end

    assign ph_off   = ADDR_W'(pos.phase) << PH_SH;
    assign slot_off = ADDR_W'(pos.slot) << SLOT_SH;
    assign wr_addr  = base_q + slot_off + ph_off;
    assign wr_valid = busy;

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
    AST_TOP_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_data[31:28] == 4'h0)); // R7
    AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid); // R9
    AST_PHASE_FOLD: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (tbl_phase <= 4'(NSTORED - 1))); // R11

endmodule

// File: tb/mirrored_coef_loader_bench.sv
module mirrored_coef_loader_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        five_tap = 1'b0;
    logic [15:0] base_addr = '0;
    logic [3:0]  tbl_phase;
    logic [83:0] tbl_row;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    int seed = 0;
    bit stall_en = 0;
    logic [7:0] lfsr = 8'hA5;

    logic [15:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [3:0]  log_tph  [64];
    int n_wr = 0;
    int n_done = 0;
    int wr_at_done = -1;
    int hold_err = 0;
    logic        prev_stall = 0;
    logic [15:0] prev_addr;
    logic [31:0] prev_data;
    int cycles = 0;

    always #2 clk = ~clk;

    mirrored_coef_loader #(.ADDR_W(16)) u_mirrored_coef_loader (
        .clk(clk), .rst(rst), .start(start), .five_tap(five_tap),
        .base_addr(base_addr), .tbl_phase(tbl_phase), .tbl_row(tbl_row),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .busy(busy), .done(done)
    );

    function automatic logic [11:0] coef(input int sd, input int p, input int k);
        int v;
        v = (p * 389 + k * 73 + sd * 211 + 17) ^ (k << 8) ^ (p << 5);
        return v[11:0];
    endfunction

    always_comb begin
        for (int k = 0; k < 7; k++) tbl_row[k*12 +: 12] = coef(seed, int'(tbl_phase), k);
    end

    function automatic logic [31:0] exp_word(input int sd, input bit five, input int p, input int w);
        logic [11:0] t [7];
        logic [11:0] s [7];
        int src;
        src = (p < 9) ? p : 16 - p;
        for (int k = 0; k < 7; k++) t[k] = coef(sd, src, (p < 9) ? k : 6 - k);
        for (int k = 0; k < 7; k++) s[k] = five ? ((k < 5) ? t[k+1] : 12'h0) : t[k];
        if (w == 0) return {4'h0, s[0], s[1], s[2][11:8]};
        if (w == 1) return {4'h0, s[2][7:0], s[3], s[4][11:4]};
        return {4'h0, s[4][3:0], s[5], s[6]};
    endfunction

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (prev_stall && (!wr_valid || wr_addr != prev_addr || wr_data != prev_data))
            hold_err <= hold_err + 1;
        prev_stall <= wr_valid && !wr_ready;
        prev_addr  <= wr_addr;
        prev_data  <= wr_data;
        if (wr_valid && wr_ready) begin
            if (n_wr < 64) begin
                log_addr[n_wr] <= wr_addr;
                log_data[n_wr] <= wr_data;
                log_tph[n_wr]  <= tbl_phase;
            end
            n_wr <= n_wr + 1;
        end
        if (done) begin
            n_done <= n_done + 1;
            wr_at_done <= n_wr;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk);
        n_wr = 0; n_done = 0; wr_at_done = -1; hold_err = 0;
    endtask

    task automatic test_reset();
        check(!wr_valid, "R1", "wr_valid after reset", wr_valid, 0);
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!done, "R1", "done after reset", done, 0);
    endtask

    task automatic run_load(input bit five, input logic [15:0] base, input int sd,
                            input bit stall, input bit collide, input string tag);
        int guard;
        int a_err, d_err, p_err;
        int first_a, first_d;
        clear_logs();
        seed = sd; stall_en = stall;
        five_tap = five; base_addr = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        five_tap = ~five; base_addr = ~base;
        guard = 0;
        while (!done && guard < 2000) begin
            if (collide && wr_valid && wr_ready && wr_addr == base + 16'h00BC) start = 1'b1;
            else if (collide && wr_valid && wr_addr == base + 16'h000C) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(done && !wr_valid && !busy, "R9", {tag, " done idle"}, {done, wr_valid, busy}, 3'b100);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 0) check(!done, "R9", {tag, " done width"}, done, 0);
            if (collide) check(!wr_valid, "R10", {tag, " no restart"}, wr_valid, 0);
        end
        check(n_wr == 48, "R2", {tag, " write count"}, n_wr, 48);
        check(n_done == 1 && wr_at_done == 48, "R9", {tag, " done after 48th"}, wr_at_done, 48);
        a_err = 0; d_err = 0; p_err = 0; first_a = -1; first_d = -1;
        for (int i = 0; i < 48; i++) begin
            int p, w;
            p = i / 3; w = i % 3;
            if (log_addr[i] != base + 16'(w * 64 + p * 4)) begin a_err++; if (first_a < 0) first_a = i; end
            if (log_data[i] != exp_word(sd, five, p, w)) begin d_err++; if (first_d < 0) first_d = i; end
            if (log_tph[i] != 4'((p < 9) ? p : 16 - p)) p_err++;
        end
        if (first_a < 0) first_a = 0;
        if (first_d < 0) first_d = 0;
        check(a_err == 0, "R3", {tag, " address"}, log_addr[first_a],
              base + 16'((first_a % 3) * 64 + (first_a / 3) * 4));
        check(d_err == 0, five ? "R7" : "R6", {tag, " packed data (R4/R5 order)"},
              log_data[first_d], exp_word(sd, five, first_d / 3, first_d % 3));
        check(p_err == 0, "R11", {tag, " table phase"}, p_err, 0);
        if (stall) check(hold_err == 0, "R8", {tag, " hold under stall"}, hold_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_load(1'b0, 16'h0080, 1, 1'b0, 1'b0, "seven-tap");
        run_load(1'b1, 16'h0200, 2, 1'b0, 1'b0, "five-tap");
        run_load(1'b0, 16'h1000, 3, 1'b1, 1'b0, "seven-tap stall");
        run_load(1'b1, 16'h0300, 4, 1'b1, 1'b0, "five-tap stall");
        run_load(1'b0, 16'h0400, 5, 1'b0, 1'b1, "collide");
        run_load(1'b1, 16'h0500, 6, 1'b1, 1'b1, "collide stall");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule